// File: doc/BRIEF.md
# Measurement Sample Sequencer

The sequencer turns one free-running system clock into the timing for a periodic battery-voltage measurement. Once per sample period it pulls an active-low gate output low, so that the external charging source pauses and the cell voltage can settle. Two back-to-back internal windows sit inside that gate window. The first is a preset window, during which a downstream counter loads its previous result. The second is a convert window, during which that counter accumulates converter pulses. A one-cycle strobe marks the end of each completed conversion.

All three windows come from a single cycle counter. Their lengths are therefore exact multiples of the same clock that drives the converter, so the number of pulses gathered during convert does not depend on the clock frequency. The defaults assume a clock of roughly 95 kHz:

| Quantity | Cycles | Approximate time |
|---|---|---|
| Sample period | 2^17 | 1.38 s |
| Gate window | 3072 | 33 ms |
| Preset window | 1024 | 11 ms |
| Convert window | 2048 | 22 ms |

A small state machine steps through four states:

| State | gate_n | preset | convert | Meaning |
|---|---|---|---|---|
| `ST_IDLE` | high | low | low | Disabled |
| `ST_PRESET` | low | high | low | Gate low, preset window |
| `ST_CONVERT` | low | low | high | Gate low, convert window |
| `ST_REST` | high | low | low | Remainder of the period |

The state machine takes these transitions:

| Transition | From | To | Taken when |
|---|---|---|---|
| start | `ST_IDLE` | `ST_PRESET` | `enable` is sampled high |
| preset_done | `ST_PRESET` | `ST_CONVERT` | The preset count expires |
| gate_done | `ST_CONVERT` | `ST_REST` | The gate count expires |
| wrap | `ST_REST` | `ST_PRESET` | The period counter reaches its last value |
| abort | any active state | `ST_IDLE` | `enable` is sampled low |

Top module: `sample_sequencer`

## Requirements
- R1: During and directly after reset, `gate_n` is 1 and `preset`, `convert` and `sample_done` are 0.
- R2: While `enable` is low, `gate_n` stays 1 and `preset`, `convert` and `sample_done` stay 0.
- R3: On the first cycle after a clock edge that samples `enable` high from the disabled state, `gate_n` goes to 0 and `preset` goes to 1 together.
- R4: `preset` stays high for exactly `PRESET_CYC` cycles, starting on the cycle in which `gate_n` falls.
- R5: `convert` rises on the cycle in which `preset` falls and stays high for `GATE_CYC - PRESET_CYC` cycles. It falls on the same cycle in which `gate_n` returns to 1, so `gate_n` is low for `GATE_CYC` cycles in total.
- R6: `preset` and `convert` are never 1 together, and both are 0 whenever `gate_n` is 1.
- R7: `sample_done` is 1 for exactly one cycle, namely the first cycle after a convert window has run to its full length. That cycle is the same cycle in which `gate_n` is back at 1.
- R8: While `enable` stays high, `gate_n` falls once every 2^`PERIOD_LOG2` cycles.
- R9: If `enable` is sampled low at any point of a window, all outputs return to the idle values on the next cycle and no `sample_done` is produced. A later enable starts a fresh window with the preset phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the sequencer; when low, the sequencer holds in the idle state |
| gate_n | output | 1 | Active-low window that pauses the charging source |
| preset | output | 1 | Preload window at the start of the gate window |
| convert | output | 1 | Counting window that follows preset |
| sample_done | output | 1 | One-cycle strobe after a completed convert window |

## Verification
The bound checker checks on every cycle the behaviours that can be seen locally in time:
- preset and convert are mutually exclusive, and both are quiet outside the gate window;
- preset rises together with the gate falling edge, and convert follows preset's fall;
- the done strobe is a single cycle and comes only after a full-length convert window;
- the outputs return to idle after `enable` is sampled low.

The exact preset and convert lengths are checked with run counters inside the checker.

Only the bench scenarios can show the remaining behaviours:
- the spacing between periods;
- the exact cycle on which the first window starts after `enable` rises;
- that a window stopped in the preset phase or on the last convert cycle produces no strobe, and restarts cleanly.

// File: rtl/sq_pkg.sv
`timescale 1ns/1ps
package sq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_PRESET  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_REST    = 2'd3
    } sq_state_t;
endpackage

// File: rtl/sq_period_counter.sv
`timescale 1ns/1ps
module sq_period_counter #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    output logic [CW-1:0] cnt
);
    // Counts while running; wraps naturally at 2^CW, which is the period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sq_window_decode.sv
`timescale 1ns/1ps
module sq_window_decode #(
    parameter int CW         = 17,
    parameter int GATE_CYC   = 3072,
    parameter int PRESET_CYC = 1024
) (
    input  logic [CW-1:0] cnt,
    output logic          preset_last,
    output logic          gate_last,
    output logic          period_last
);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRESET_CYC - 1);
    localparam logic [CW-1:0] GATE_LAST = CW'(GATE_CYC - 1);
    localparam logic [CW-1:0] PER_LAST  = '1;

    always_comb begin
        preset_last = (cnt == PRE_LAST);
        gate_last   = (cnt == GATE_LAST);
        period_last = (cnt == PER_LAST);
    end
endmodule

// File: rtl/sq_phase_fsm.sv
`timescale 1ns/1ps
module sq_phase_fsm
    import sq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      enable,
    input  logic      preset_last,
    input  logic      gate_last,
    input  logic      period_last,
    output logic      run,
    output logic      gate_n,
    output logic      preset,
    output logic      convert,
    output logic      sample_done
);
    sq_state_t state, nxt;

    // Next-state selection: start, preset_done, gate_done, wrap, abort.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    nxt = enable ? ST_PRESET : ST_IDLE;
            ST_PRESET:  nxt = !enable ? ST_IDLE : (preset_last ? ST_CONVERT : ST_PRESET);
            ST_CONVERT: nxt = !enable ? ST_IDLE : (gate_last ? ST_REST : ST_CONVERT);
            ST_REST:    nxt = !enable ? ST_IDLE : (period_last ? ST_PRESET : ST_REST);
            default:    nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Completion strobe: set only on a normal CONVERT -> REST step.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_done <= 1'b0;
        end else begin
            sample_done <= (state == ST_CONVERT) && enable && gate_last;
        end
    end

    // Output decode from the registered state.
    always_comb begin
        run     = enable && (state != ST_IDLE);
        gate_n  = 1'b1;
        preset  = 1'b0;
        convert = 1'b0;
        unique case (state)
            ST_PRESET: begin
                gate_n = 1'b0;
                preset = 1'b1;
            end
            ST_CONVERT: begin
                gate_n  = 1'b0;
                convert = 1'b1;
            end
            default: begin
                gate_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/sample_sequencer.sv
`timescale 1ns/1ps
module sample_sequencer #(
    parameter int PERIOD_LOG2 = 17,
    parameter int GATE_CYC    = 3072,
    parameter int PRESET_CYC  = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic gate_n,
    output logic preset,
    output logic convert,
    output logic sample_done
);
    localparam int CW = PERIOD_LOG2;

    // Parameter legality: preset < gate < period.
    generate
        if (PRESET_CYC < 1 || GATE_CYC <= PRESET_CYC || GATE_CYC >= (1 << PERIOD_LOG2)) begin : g_bad_params
            initial $error("sample_sequencer: window parameters out of range");
        end
    endgenerate

    logic [CW-1:0] cnt;
    logic          run;
    logic          preset_last;
    logic          gate_last;
    logic          period_last;

    sq_period_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .cnt   (cnt)
    );

    sq_window_decode #(
        .CW         (CW),
        .GATE_CYC   (GATE_CYC),
        .PRESET_CYC (PRESET_CYC)
    ) u_dec (
        .cnt         (cnt),
        .preset_last (preset_last),
        .gate_last   (gate_last),
        .period_last (period_last)
    );

    sq_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .preset_last (preset_last),
        .gate_last   (gate_last),
        .period_last (period_last),
        .run         (run),
        .gate_n      (gate_n),
        .preset      (preset),
        .convert     (convert),
        .sample_done (sample_done)
    );
endmodule

// File: rtl/sample_sequencer_chk.sv
`timescale 1ns/1ps
module sample_sequencer_chk #(
    parameter int GATE_CYC   = 3072,
    parameter int PRESET_CYC = 1024
) (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic gate_n,
    input logic preset,
    input logic convert,
    input logic sample_done
);
    localparam int CONV_CYC = GATE_CYC - PRESET_CYC;

    int pre_run;
    int conv_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_run  <= 0;
            conv_run <= 0;
        end else begin
            pre_run  <= preset  ? pre_run + 1  : 0;
            conv_run <= convert ? conv_run + 1 : 0;
        end
    end

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(preset && convert));
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gate_n |-> (!preset && !convert));
    p_preset_on_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate_n) |-> preset);
    p_preset_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(convert) |-> (pre_run == PRESET_CYC));
    p_convert_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(preset) |-> (convert || gate_n));
    p_done_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_done |-> (conv_run == CONV_CYC));
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_done |=> !sample_done);
    p_done_after_convert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_done |-> (gate_n && $past(convert)));
    p_disable_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (gate_n && !preset && !convert && !sample_done));
endmodule

bind sample_sequencer sample_sequencer_chk #(
    .GATE_CYC   (GATE_CYC),
    .PRESET_CYC (PRESET_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .gate_n      (gate_n),
    .preset      (preset),
    .convert     (convert),
    .sample_done (sample_done)
);

// File: tb/sim_sample_sequencer.sv
`timescale 1ns/1ps
module sim_sample_sequencer;
    localparam int LOG2 = 6;
    localparam int PER  = 1 << LOG2;
    localparam int GATE = 12;
    localparam int PRE  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic gate_n, preset, convert, sample_done;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sample_sequencer #(
        .PERIOD_LOG2 (LOG2),
        .GATE_CYC    (GATE),
        .PRESET_CYC  (PRE)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .gate_n      (gate_n),
        .preset      (preset),
        .convert     (convert),
        .sample_done (sample_done)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_idle(input string req);
        chk(gate_n == 1'b1, req, "gate_n", int'(gate_n), 1);
        chk(preset == 1'b0, req, "preset", int'(preset), 0);
        chk(convert == 1'b0, req, "convert", int'(convert), 0);
        chk(sample_done == 1'b0, req, "sample_done", int'(sample_done), 0);
    endtask

    // Compare outputs with the expected schedule at cycle k of a run.
    task automatic expect_phase(input int k, input string gate_req);
        int m = k % PER;
        logic e_pre  = (m < PRE);
        logic e_conv = (m >= PRE) && (m < GATE);
        logic e_gate = !(m < GATE);
        logic e_done = (k >= GATE) && (m == GATE);
        chk(gate_n == e_gate, gate_req, "gate_n", int'(gate_n), int'(e_gate));
        chk(preset == e_pre, "R4", "preset", int'(preset), int'(e_pre));
        chk(convert == e_conv, "R5", "convert", int'(convert), int'(e_conv));
        chk(sample_done == e_done, "R7", "sample_done", int'(sample_done), int'(e_done));
        chk(!(preset && convert) && !(gate_n && (preset || convert)), "R6",
            "overlap", int'({preset, convert}), 0);
    endtask

    task automatic test_reset();
        expect_idle("R1");
        rst_n = 1'b1;
        tick();
        expect_idle("R1");
    endtask

    task automatic test_disabled();
        enable = 1'b0;
        for (int i = 0; i < 40; i++) begin
            tick();
            expect_idle("R2");
        end
    endtask

    task automatic test_run();
        int last_fall = -1;
        logic prev_gate = 1'b1;
        enable = 1'b1;
        for (int k = 0; k < 2 * PER + 20; k++) begin
            tick();
            expect_phase(k, (k == 0) ? "R3" : "R8");
            if (prev_gate && !gate_n) begin
                if (last_fall >= 0) chk(k - last_fall == PER, "R8", "period", k - last_fall, PER);
                last_fall = k;
            end
            prev_gate = gate_n;
        end
        chk(last_fall == 2 * PER, "R8", "last fall", last_fall, 2 * PER);
        enable = 1'b0;
        tick();
        expect_idle("R9");
        for (int i = 0; i < 5; i++) begin
            tick();
            expect_idle("R2");
        end
    endtask

    // Stop a window after `stop_k` active cycles, then restart.
    task automatic test_abort(input int stop_k);
        enable = 1'b1;
        for (int k = 0; k <= stop_k; k++) begin
            tick();
            expect_phase(k, "R3");
        end
        enable = 1'b0;
        for (int i = 0; i < 10; i++) begin
            tick();
            expect_idle("R9");
        end
        enable = 1'b1;
        for (int k = 0; k < GATE + 4; k++) begin
            tick();
            expect_phase(k, (k == 0) ? "R9" : "R5");
        end
        enable = 1'b0;
        tick();
        expect_idle("R9");
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #3;
        test_reset();
        test_disabled();
        test_run();
        test_abort(2);
        test_abort(GATE - 1);
        test_abort(PRE);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule